// File: doc/BRIEF.md
# Banked GPIO Controller with Per-Pin Mode Nibbles

This block controls sixteen general-purpose pins through a small memory-mapped register file. The pins are grouped into four banks of unequal size: two pins, four, four, then six. Each bank owns one data register and one configuration register. In the configuration register every pin has a four-bit mode nibble. One code makes the pin an input and a different code makes it an output. Any other code leaves the pin undriven. A single shared register chooses, for each pin, whether an output pin is driven actively or behaves as open-drain.

The data register has two faces. For an output pin, the stored bit sets the level driven on the pin. For an input pin, a read returns the pad level after it passes through a two-flop synchronizer. For a pin in any other mode, a read returns the stored bit. Register accesses arrive on a valid/ready request channel. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. Only reads produce a response. The response appears on a valid/ready channel and is held, unchanged, until `rsp_ready` is high. While a response is waiting and `rsp_ready` is low, `req_ready` is low, so a pending response back-pressures the request channel.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset, every pin has `pin_oe` low and `pin_out` low, and every mapped register reads 0.
- R2: Writing mode code 0x8 into the nibble at bits [4i+3:4i] of a bank's configuration register makes pin i of that bank an output. Its `pin_oe` is high and its `pin_out` equals bit i of the bank's data register. Reading the data register returns the stored bits.
- R3: When a pin's bit in the drive register (offset 0x190, bit = global pin number) is 1 and the pin is an output, `pin_oe` is high only while the data bit is 0, and `pin_out` is 0. `pin_out` is never high on such a pin.
- R4: Mode code 0x1 makes a pin an input with `pin_oe` low. Reading its data bit returns the pin level through two synchronizer flops. A read accepted on the clock edge right after the level changes (the level is presented one cycle before) still returns the old level. Writes to the data bit do not alter what is read.
- R5: A mode code other than 0x1 and 0x8 leaves the pin undriven (`pin_oe` and `pin_out` low). Its data bit reads back the stored value. `pin_out` is high only when `pin_oe` is high.
- R6: Data bits and mode nibbles above a bank's pin count read as 0 and ignore writes. Drive register bits 31:16 read as 0.
- R7: Data registers are at offsets 0x170, 0x174, 0x178, 0x17C, in bank order. Configuration registers are at 0x180, 0x184, 0x188, 0x18C. Any other offset reads 0, and a write to it has no effect.
- R8: A read accepted on a clock edge raises `rsp_valid` after that edge. `rsp_valid` and `rsp_rdata` hold while `rsp_ready` is low, and `req_ready` is low during that time.
- R9: An accepted write produces no response, and its effect on the pins is visible right after the accepting edge.
- R10: A write request stalled by back-pressure changes nothing until it is accepted. It is then accepted on the same edge that consumes the pending response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request may be accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Consumer takes read data |
| rsp_rdata | output | 32 | Read data |
| pin_in | input | 16 | Sampled pad levels |
| pin_out | output | 16 | Pad output levels |
| pin_oe | output | 16 | Pad output enables |

## Verification
A read response held by a low `rsp_ready` and a new write request can both be present in the same cycle. The bench provokes this by parking a read response, then presenting a write that would change several pins. For several cycles it confirms that the pins, `rsp_rdata` and `req_ready` stay unchanged. When `rsp_ready` is raised, it confirms that the response leaves and the write lands on the same edge. A second overlap, between a pin level change and a read of that pin's data bit, is forced on adjacent edges to pin down the synchronizer delay.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  localparam int NUM_PINS   = 16;
  localparam int NUM_BANKS  = 4;
  localparam int MODE_W     = 4;
  localparam int DATA_W     = 32;
  localparam int ADDR_W     = 12;
  localparam int BANK_STEP  = 4;

  localparam logic [MODE_W-1:0] MODE_IN  = 4'h1;
  localparam logic [MODE_W-1:0] MODE_OUT = 4'h8;

  localparam logic [ADDR_W-1:0] DATA_ADDR0 = 12'h170;
  localparam logic [ADDR_W-1:0] CFG_ADDR0  = 12'h180;
  localparam logic [ADDR_W-1:0] DRIVE_ADDR = 12'h190;

  typedef struct packed {
    logic              write;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
  } bus_req_t;

  function automatic int bank_width(input int b);
    case (b)
      0:       return 2;
      1:       return 4;
      2:       return 4;
      default: return 6;
    endcase
  endfunction

  function automatic int bank_base(input int b);
    int acc;
    acc = 0;
    for (int k = 0; k < b; k++) acc += bank_width(k);
    return acc;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_pkg::*;
#(
  parameter int                WIDTH     = 4,
  parameter logic [ADDR_W-1:0] DATA_ADDR = DATA_ADDR0,
  parameter logic [ADDR_W-1:0] CFG_ADDR  = CFG_ADDR0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [DATA_W-1:0]         wdata,
  input  logic [WIDTH-1:0]          sync_in,
  output logic [WIDTH*MODE_W-1:0]   mode_o,
  output logic [WIDTH-1:0]          data_o,
  output logic [DATA_W-1:0]         rd_val
);
  localparam int CFG_BITS = WIDTH * MODE_W;

  logic [WIDTH-1:0]    data_q;
  logic [CFG_BITS-1:0] mode_q;
  logic                hit_data;
  logic                hit_cfg;

  assign hit_data = (addr == DATA_ADDR);
  assign hit_cfg  = (addr == CFG_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      mode_q <= '0;
    end else if (wr_en) begin
      if (hit_data) data_q <= wdata[WIDTH-1:0];
      if (hit_cfg)  mode_q <= wdata[CFG_BITS-1:0];
    end
  end

  always_comb begin
    rd_val = '0;
    if (hit_data) begin
      for (int i = 0; i < WIDTH; i++) begin
        rd_val[i] = (mode_q[i*MODE_W +: MODE_W] == MODE_IN) ? sync_in[i] : data_q[i];
      end
    end else if (hit_cfg) begin
      rd_val[CFG_BITS-1:0] = mode_q;
    end
  end

  assign mode_o = mode_q;
  assign data_o = data_q;
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
  import gpio_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  input  logic              level,
  input  logic              open_drain,
  output logic              pad_out,
  output logic              pad_oe
);
  always_comb begin
    pad_out = 1'b0;
    pad_oe  = 1'b0;
    if (mode == MODE_OUT) begin
      if (open_drain) begin
        pad_oe  = ~level;
        pad_out = 1'b0;
      end else begin
        pad_oe  = 1'b1;
        pad_out = level;
      end
    end
  end
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [DATA_W-1:0]   rsp_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe
);
  bus_req_t                   req;
  logic                       req_fire;
  logic                       wr_fire;
  logic [NUM_PINS-1:0]        pin_sync;
  logic [NUM_PINS-1:0]        drive_q;
  logic [NUM_PINS*MODE_W-1:0] mode_all;
  logic [NUM_PINS-1:0]        data_all;
  logic [DATA_W-1:0]          bank_rd [NUM_BANKS];
  logic [DATA_W-1:0]          rd_mux;

  assign req       = '{write: req_write, addr: req_addr, wdata: req_wdata};
  assign req_ready = ~rsp_valid | rsp_ready;
  assign req_fire  = req_valid & req_ready;
  assign wr_fire   = req_fire & req.write;

  gpio_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pin_in),
    .sync_out (pin_sync)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int BW   = bank_width(b);
    localparam int BB   = bank_base(b);
    localparam logic [ADDR_W-1:0] DADDR = DATA_ADDR0 + ADDR_W'(b * BANK_STEP);
    localparam logic [ADDR_W-1:0] CADDR = CFG_ADDR0  + ADDR_W'(b * BANK_STEP);

    gpio_bank #(
      .WIDTH     (BW),
      .DATA_ADDR (DADDR),
      .CFG_ADDR  (CADDR)
    ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_fire),
      .addr    (req.addr),
      .wdata   (req.wdata),
      .sync_in (pin_sync[BB +: BW]),
      .mode_o  (mode_all[BB*MODE_W +: BW*MODE_W]),
      .data_o  (data_all[BB +: BW]),
      .rd_val  (bank_rd[b])
    );
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pad
    gpio_pad_ctrl u_pad (
      .mode       (mode_all[p*MODE_W +: MODE_W]),
      .level      (data_all[p]),
      .open_drain (drive_q[p]),
      .pad_out    (pin_out[p]),
      .pad_oe     (pin_oe[p])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drive_q <= '0;
    end else if (wr_fire && (req.addr == DRIVE_ADDR)) begin
      drive_q <= req.wdata[NUM_PINS-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int b = 0; b < NUM_BANKS; b++) rd_mux |= bank_rd[b];
    if (req.addr == DRIVE_ADDR) rd_mux[NUM_PINS-1:0] = drive_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;
      if (req_fire && !req.write) begin
        rsp_valid <= 1'b1;
        rsp_rdata <= rd_mux;
      end
    end
  end
endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk
  import gpio_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_ready,
  input logic                req_write,
  input logic                rsp_valid,
  input logic                rsp_ready,
  input logic [DATA_W-1:0]   rsp_rdata,
  input logic [NUM_PINS-1:0] pin_out,
  input logic [NUM_PINS-1:0] pin_oe,
  input logic [NUM_PINS-1:0] drive_q
);
  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata))) else $error("rsp not held"); // R8

  AST_READ_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> rsp_valid) else $error("no read rsp"); // R8

  AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!rsp_valid && req_valid && req_ready && req_write) |=> !rsp_valid) else $error("write rsp"); // R9

  AST_STALL_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> ($stable(pin_oe) && $stable(pin_out))) else $error("stalled write acted"); // R10

  AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ((drive_q & pin_out) == '0)) else $error("open-drain pin driven high"); // R3

  AST_OUT_NEEDS_OE: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_out & ~pin_oe) == '0)) else $error("out high while undriven"); // R5
endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk u_chk (.*);

// File: tb/gpio_bank_ctrl_tb.sv
module gpio_bank_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;
  logic [15:0] pin_in = '0;
  logic [15:0] pin_out;
  logic [15:0] pin_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_bank_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8 rsp_valid after read", {31'b0, rsp_valid}, 32'h1);
    d = rsp_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 pin_oe", {16'b0, pin_oe}, 32'h0);
    chk("R1 pin_out", {16'b0, pin_out}, 32'h0);
    for (int b = 0; b < 4; b++) begin
      bus_read(12'h170 + 12'(4*b), d); chk("R1 data reg", d, 32'h0);
      bus_read(12'h180 + 12'(4*b), d); chk("R1 cfg reg", d, 32'h0);
    end
    bus_read(12'h190, d); chk("R1 drive reg", d, 32'h0);
  endtask

  task automatic t_push_pull;
    logic [31:0] d;
    bus_write(12'h184, 32'h0000_8888);
    bus_write(12'h174, 32'h0000_000A);
    chk("R9 R2 pin_oe right after write", {16'b0, pin_oe}, 32'h003C);
    chk("R2 pin_out", {16'b0, pin_out}, 32'h0028);
    bus_read(12'h174, d); chk("R2 data readback", d, 32'h0000_000A);
    bus_read(12'h184, d); chk("R2 cfg readback", d, 32'h0000_8888);
  endtask

  task automatic t_open_drain;
    logic [31:0] d;
    bus_write(12'h190, 32'h0000_000C);
    chk("R3 pin_oe", {16'b0, pin_oe}, 32'h0034);
    chk("R3 pin_out", {16'b0, pin_out}, 32'h0020);
    bus_read(12'h190, d); chk("R3 drive readback", d, 32'h0000_000C);
  endtask

  task automatic t_input;
    logic [31:0] d;
    bus_write(12'h18C, 32'h0011_1111);
    pin_in = 16'hA400;
    repeat (3) @(negedge clk);
    chk("R4 input pins undriven", {16'b0, pin_oe & 16'hFC00}, 32'h0);
    bus_read(12'h17C, d); chk("R4 sampled level", d, 32'h0000_0029);
    bus_write(12'h17C, 32'h0000_003F);
    bus_read(12'h17C, d); chk("R4 write does not alter read", d, 32'h0000_0029);
    @(negedge clk);
    pin_in = 16'h0000;
    bus_read(12'h17C, d); chk("R4 synchronizer delay", d, 32'h0000_0029);
    repeat (3) @(negedge clk);
    bus_read(12'h17C, d); chk("R4 new level", d, 32'h0);
  endtask

  task automatic t_other_mode;
    logic [31:0] d;
    bus_write(12'h180, 32'h0000_0032);
    bus_write(12'h170, 32'h0000_0003);
    chk("R5 pins undriven oe", {30'b0, pin_oe[1:0]}, 32'h0);
    chk("R5 pins undriven out", {30'b0, pin_out[1:0]}, 32'h0);
    bus_read(12'h170, d); chk("R5 stored data readback", d, 32'h3);
  endtask

  task automatic t_backpressure;
    logic [31:0] d;
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 12'h174;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 12'h174; req_wdata = 32'h0;
    chk("R8 response parked", {31'b0, rsp_valid}, 32'h1);
    chk("R8 parked data", rsp_rdata, 32'hA);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R8 req_ready low while parked", {31'b0, req_ready}, 32'h0);
      chk("R8 parked data stable", rsp_rdata, 32'hA);
      chk("R10 stalled write no effect oe", {16'b0, pin_oe}, 32'h0034);
      chk("R10 stalled write no effect out", {16'b0, pin_out}, 32'h0020);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    chk("R10 response consumed", {31'b0, rsp_valid}, 32'h0);
    chk("R10 write landed oe", {16'b0, pin_oe}, 32'h003C);
    chk("R10 write landed out", {16'b0, pin_out}, 32'h0);
    bus_read(12'h174, d); chk("R10 data after write", d, 32'h0);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    bus_write(12'h194, 32'hFFFF_FFFF);
    bus_write(12'h160, 32'hFFFF_FFFF);
    chk("R7 unmapped write oe", {16'b0, pin_oe}, 32'h003C);
    chk("R7 unmapped write out", {16'b0, pin_out}, 32'h0);
    bus_read(12'h194, d); chk("R7 unmapped read", d, 32'h0);
    bus_read(12'h188, d); chk("R7 bank2 cfg untouched", d, 32'h0);
    bus_read(12'h190, d); chk("R7 drive untouched", d, 32'hC);
  endtask

  task automatic t_width;
    logic [31:0] d;
    bus_write(12'h170, 32'hFFFF_FFFF);
    bus_read(12'h170, d); chk("R6 bank0 data width", d, 32'h3);
    bus_write(12'h180, 32'hFFFF_FFFF);
    bus_read(12'h180, d); chk("R6 bank0 cfg width", d, 32'hFF);
    bus_write(12'h190, 32'hFFFF_FFFF);
    bus_read(12'h190, d); chk("R6 drive width", d, 32'hFFFF);
    chk("R6 R5 mode F undriven", {30'b0, pin_oe[1:0]}, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R8 watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_push_pull();
    t_open_drain();
    t_input();
    t_other_mode();
    t_backpressure();
    t_unmapped();
    t_width();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule